// File: doc/BRIEF.md
# Secure-Aware APB Register Bank

This block is a 32-bit APB4 slave holding a small bank of control and status words. Each word has an access type: read-write, read-only or write-only. Read-only words show hardware status inputs. Read-write and write-only words drive configuration outputs. Two of the registers are 64 bits wide. Each of them is reached as a low word and a high word at two separate word addresses, and each word is accessed on its own, so a 64-bit update is not atomic.

Some words are marked Secure. The transaction's security state comes from the protection attribute: `pprot[1] = 1` means non-secure. A non-secure transaction that targets a Secure word is filtered out. Bits a word does not implement are masked according to that word's access type. Offsets with no word behind them, including offsets left empty on purpose, read as zero and ignore writes.

Every transfer finishes in its access phase without wait states and without an error response. Filtered and unmapped transfers finish the same way.

Word map (byte offset, type, Secure, implemented bits):

| Offset | Name | Type | Secure | Implemented bits |
|---|---|---|---|---|
| 0x00 | CTRL | RW | no | 15:0 |
| 0x04 | STAT | RO (`stat_i`) | no | 7:0 |
| 0x08 | CMD | WO | no | 11:0 |
| 0x10 | BASE low | RW | no | 31:6 |
| 0x14 | BASE high | RW | no | 15:0 |
| 0x18 | CNT low | RO (`cnt_i[31:0]`) | no | 31:0 |
| 0x1C | CNT high | RO (`cnt_i[63:32]`) | no | 31:0 |
| 0x20 | SCTRL | RW | yes | 7:0 |
| 0x24 | SSTAT | RO (`sstat_i`) | yes | 15:0 |

Top module: `sec_apb_regbank`

## Requirements
- R1: After `presetn` is low, every stored bit is 0: `ctrl_o`, `cmd_o`, `base_o` and `sctrl_o` read 0, and reads of CTRL, BASE and SCTRL return 0.
- R2: A write to an RW word updates only its implemented bits, and a read returns them. Unimplemented bits read 0 and ignore writes. For example, CTRL bits 31:16 and BASE low bits 5:0 always read 0.
- R3: A read of an RO word returns its status input ANDed with the implemented-bit mask. A write to an RO word has no effect.
- R4: A read of the WO word CMD returns 0. A write to CMD updates `cmd_o` in bits 11:0 only.
- R5: `pstrb[b]` enables byte b (bits 8b+7:8b) of a write. Bytes whose strobe is 0 keep their old value.
- R6: The low and high words of a 64-bit register (BASE at 0x10/0x14, CNT at 0x18/0x1C) are accessed on their own. A write to one half leaves the other half unchanged.
- R7: When `pprot[1]` is 1 (non-secure), a read of SCTRL or SSTAT returns 0 and a write to them has no effect. When `pprot[1]` is 0, both behave as their type defines.
- R8: A read of any offset in the map's range that no word occupies (for example 0x0C, 0x28 to 0x3C, and 0x2C as a deliberately empty offset) returns 0, and a write to it changes no register.
- R9: Every transfer completes in its access phase: `pready` is 1 and `pslverr` is 0, for mapped, filtered and unmapped offsets alike.
- R10: A register changes only on a write access phase (`psel`, `penable` and `pwrite` all 1). A setup phase alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase indicator |
| pwrite | input | 1 | 1 for a write transfer |
| paddr | input | ADDR_W | Byte address; bits 1:0 ignored |
| pprot | input | 3 | Protection attribute; bit 1 set means non-secure |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte write enables |
| prdata | output | 32 | Read data, valid in a read access phase, else 0 |
| pready | output | 1 | Transfer done, always 1 |
| pslverr | output | 1 | Error response, always 0 |
| stat_i | input | 32 | Status shown through STAT |
| cnt_i | input | 64 | 64-bit status shown through CNT low/high |
| sstat_i | input | 32 | Secure status shown through SSTAT |
| ctrl_o | output | 32 | Contents of CTRL |
| cmd_o | output | 32 | Last value written to CMD |
| base_o | output | 64 | Contents of BASE, high word in bits 63:32 |
| sctrl_o | output | 32 | Contents of SCTRL |

## Verification
The bench sweeps every word offset in the decoded range. It writes a different pattern on each round, under both security states and with full, even-byte and odd-byte strobe masks, and reads every offset back under both states. A design that decoded the Secure flag the wrong way round, or filtered only reads, would let non-secure writes reach SCTRL or hide its value from secure reads. A design that ignored the strobes or the per-word masks would show data in reserved bits or in bytes that were not enabled. A design that treated the two halves of a 64-bit register as one unit would overwrite the untouched half. Dedicated checks cover the WO read, writes to RO words, unmapped offsets and a setup phase that is never followed by an access phase.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int unsigned NWORDS = 9;
  localparam int unsigned DW     = 32;
  localparam int unsigned NBYTES = DW / 8;

  localparam int unsigned W_CTRL  = 0;
  localparam int unsigned W_STAT  = 1;
  localparam int unsigned W_CMD   = 2;
  localparam int unsigned W_BLO   = 3;
  localparam int unsigned W_BHI   = 4;
  localparam int unsigned W_CLO   = 5;
  localparam int unsigned W_CHI   = 6;
  localparam int unsigned W_SCTRL = 7;
  localparam int unsigned W_SSTAT = 8;

  typedef enum logic [1:0] {
    ACC_RW = 2'd0,
    ACC_RO = 2'd1,
    ACC_WO = 2'd2
  } acc_e;

  typedef struct packed {
    logic [11:0]   offs;
    acc_e          acc;
    logic          sec;
    logic [DW-1:0] mask;
  } word_desc_t;

  // Fixed word map: byte offset, access type, secure flag, implemented bits.
  function automatic word_desc_t desc_of(input int unsigned idx);
    word_desc_t d;
    case (idx)
      W_CTRL:  d = '{offs: 12'h000, acc: ACC_RW, sec: 1'b0, mask: 32'h0000_FFFF};
      W_STAT:  d = '{offs: 12'h004, acc: ACC_RO, sec: 1'b0, mask: 32'h0000_00FF};
      W_CMD:   d = '{offs: 12'h008, acc: ACC_WO, sec: 1'b0, mask: 32'h0000_0FFF};
      W_BLO:   d = '{offs: 12'h010, acc: ACC_RW, sec: 1'b0, mask: 32'hFFFF_FFC0};
      W_BHI:   d = '{offs: 12'h014, acc: ACC_RW, sec: 1'b0, mask: 32'h0000_FFFF};
      W_CLO:   d = '{offs: 12'h018, acc: ACC_RO, sec: 1'b0, mask: 32'hFFFF_FFFF};
      W_CHI:   d = '{offs: 12'h01C, acc: ACC_RO, sec: 1'b0, mask: 32'hFFFF_FFFF};
      W_SCTRL: d = '{offs: 12'h020, acc: ACC_RW, sec: 1'b1, mask: 32'h0000_00FF};
      W_SSTAT: d = '{offs: 12'h024, acc: ACC_RO, sec: 1'b1, mask: 32'h0000_FFFF};
      default: d = '{offs: 12'hFFC, acc: ACC_RO, sec: 1'b1, mask: 32'h0};
    endcase
    return d;
  endfunction

  // Expand byte strobes into a bit mask.
  function automatic logic [DW-1:0] byte_lanes(input logic [NBYTES-1:0] strb);
    logic [DW-1:0] m;
    for (int b = 0; b < NBYTES; b++) m[8*b +: 8] = {8{strb[b]}};
    return m;
  endfunction

  // New stored value: only enabled bytes of implemented bits take write data.
  function automatic logic [DW-1:0] merge_write(input logic [DW-1:0] old_v,
                                                input logic [DW-1:0] wdat,
                                                input logic [NBYTES-1:0] strb,
                                                input logic [DW-1:0] impl);
    logic [DW-1:0] sel;
    sel = byte_lanes(strb) & impl;
    return (old_v & ~sel) | (wdat & sel);
  endfunction

  // Value a read returns for one word, given whether the access may see it.
  function automatic logic [DW-1:0] read_view(input logic [DW-1:0] stored,
                                              input logic [DW-1:0] hw,
                                              input word_desc_t d,
                                              input logic visible);
    logic [DW-1:0] v;
    if (!visible)              v = '0;
    else if (d.acc == ACC_RW)  v = stored & d.mask;
    else if (d.acc == ACC_RO)  v = hw & d.mask;
    else                       v = '0;
    return v;
  endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ns,
  output logic [NWORDS-1:0] hit,
  output logic [NWORDS-1:0] allow
);

  for (genvar g = 0; g < NWORDS; g++) begin : g_dec
    localparam word_desc_t D = desc_of(g);
    localparam logic [ADDR_W-1:0] WANT = ADDR_W'(D.offs);
    assign hit[g]   = (addr[ADDR_W-1:2] == WANT[ADDR_W-1:2]);
    assign allow[g] = hit[g] && !(D.sec && ns);
  end

  // R8: at most one word answers a given offset
  p_hit_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: rtl/regbank_word.sv
module regbank_word
  import regbank_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  input  logic [NBYTES-1:0] strb,
  output logic [DW-1:0]     q
);

  localparam word_desc_t D = desc_of(IDX);
  localparam bit HAS_STORE = (D.acc != ACC_RO);

  if (HAS_STORE) begin : g_store
    logic [DW-1:0] q_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_r <= '0;
      else if (we) q_r <= merge_write(q_r, wdata, strb, D.mask);
    end
    assign q = q_r;
  end else begin : g_nostore
    logic unused_ro_in;
    assign unused_ro_in = ^{clk, rst_n, we, wdata, strb};
    assign q = '0;
  end

endmodule

// File: rtl/sec_apb_regbank.sv
module sec_apb_regbank
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [2:0]        pprot,
  input  logic [31:0]       pwdata,
  input  logic [3:0]        pstrb,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [31:0]       stat_i,
  input  logic [63:0]       cnt_i,
  input  logic [31:0]       sstat_i,
  output logic [31:0]       ctrl_o,
  output logic [31:0]       cmd_o,
  output logic [63:0]       base_o,
  output logic [31:0]       sctrl_o
);

  // Named bus events
  logic ns;
  logic wr_acc;
  logic rd_acc;
  assign ns     = pprot[1];
  assign wr_acc = psel && penable && pwrite;
  assign rd_acc = psel && penable && !pwrite;

  logic unused_bits;
  assign unused_bits = ^{pprot[2], pprot[0], paddr[1:0]};

  logic [NWORDS-1:0] hit;
  logic [NWORDS-1:0] allow;

  regbank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk   (pclk),
    .rst_n (presetn),
    .addr  (paddr),
    .ns    (ns),
    .hit   (hit),
    .allow (allow)
  );

  logic [DW-1:0] word_q  [NWORDS];
  logic [DW-1:0] hw_word [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    regbank_word #(.IDX(g)) u_w (
      .clk   (pclk),
      .rst_n (presetn),
      .we    (wr_acc && allow[g]),
      .wdata (pwdata),
      .strb  (pstrb),
      .q     (word_q[g])
    );
  end

  always_comb begin
    for (int i = 0; i < NWORDS; i++) hw_word[i] = '0;
    hw_word[W_STAT]  = stat_i;
    hw_word[W_CLO]   = cnt_i[31:0];
    hw_word[W_CHI]   = cnt_i[63:32];
    hw_word[W_SSTAT] = sstat_i;
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (hit[i]) rd_mux = rd_mux | read_view(word_q[i], hw_word[i], desc_of(i), allow[i]);
    end
  end

  assign prdata  = rd_acc ? rd_mux : '0;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  assign ctrl_o  = word_q[W_CTRL];
  assign cmd_o   = word_q[W_CMD];
  assign base_o  = {word_q[W_BHI], word_q[W_BLO]};
  assign sctrl_o = word_q[W_SCTRL];

  // R2: reserved CTRL bits never appear on the bus
  p_rsvd_ctrl_zero_r2: assert property (@(posedge pclk) disable iff (!presetn)
    (rd_acc && hit[W_CTRL]) |-> (prdata[31:16] == 16'h0));

  // R4: write-only word reads as zero
  p_wo_read_zero_r4: assert property (@(posedge pclk) disable iff (!presetn)
    (rd_acc && hit[W_CMD]) |-> (prdata == 32'h0));

  // R6: writing the low half of BASE keeps the high half
  p_half_indep_r6: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_acc && hit[W_BLO]) |=> $stable(base_o[63:32]));

  // R7: non-secure write to a secure word is dropped
  p_ns_sec_write_r7: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_acc && ns && hit[W_SCTRL]) |=> $stable(sctrl_o));

  // R7: non-secure read of a secure word returns zero
  p_ns_sec_read_r7: assert property (@(posedge pclk) disable iff (!presetn)
    (rd_acc && ns && (hit[W_SCTRL] || hit[W_SSTAT])) |-> (prdata == 32'h0));

  // R8: unmapped offsets read as zero
  p_unmapped_read_r8: assert property (@(posedge pclk) disable iff (!presetn)
    (rd_acc && (hit == '0)) |-> (prdata == 32'h0));

  // R10: nothing changes outside a write access phase
  p_no_write_outside_access_r10: assert property (@(posedge pclk) disable iff (!presetn)
    !wr_acc |=> ($stable(ctrl_o) && $stable(cmd_o) && $stable(base_o) && $stable(sctrl_o)));

endmodule

// File: tb/sim_sec_apb_regbank.sv
module sim_sec_apb_regbank;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [2:0]  pprot = '0;
  logic [31:0] pwdata = '0;
  logic [3:0]  pstrb = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [31:0] stat_i = '0, sstat_i = '0;
  logic [63:0] cnt_i = '0;
  logic [31:0] ctrl_o, cmd_o, sctrl_o;
  logic [63:0] base_o;

  always #5 pclk = ~pclk;

  sec_apb_regbank #(.ADDR_W(12)) u0 (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pprot(pprot), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .stat_i(stat_i), .cnt_i(cnt_i), .sstat_i(sstat_i),
    .ctrl_o(ctrl_o), .cmd_o(cmd_o), .base_o(base_o), .sctrl_o(sctrl_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench model of stored words
  logic [31:0] m_ctrl = '0, m_cmd = '0, m_blo = '0, m_bhi = '0, m_sctrl = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] s);
    logic [31:0] m = '0;
    for (int b = 0; b < 4; b++) if (s[b]) m = m | (32'hFF << (8 * b));
    return m;
  endfunction

  function automatic logic [31:0] upd(input logic [31:0] o, input logic [31:0] d,
                                      input logic [3:0] s, input logic [31:0] keep);
    logic [31:0] e = lanes(s) & keep;
    return (o & ~e) | (d & e);
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d,
                             input logic [3:0] s, input bit nsec);
    case (a[11:2])
      10'd0: m_ctrl = upd(m_ctrl, d, s, 32'h0000_FFFF);
      10'd2: m_cmd  = upd(m_cmd,  d, s, 32'h0000_0FFF);
      10'd4: m_blo  = upd(m_blo,  d, s, 32'hFFFF_FFC0);
      10'd5: m_bhi  = upd(m_bhi,  d, s, 32'h0000_FFFF);
      10'd8: if (!nsec) m_sctrl = upd(m_sctrl, d, s, 32'h0000_00FF);
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_read(input logic [11:0] a, input bit nsec);
    case (a[11:2])
      10'd0: return m_ctrl;
      10'd1: return stat_i & 32'hFF;
      10'd4: return m_blo;
      10'd5: return m_bhi;
      10'd6: return cnt_i[31:0];
      10'd7: return cnt_i[63:32];
      10'd8: return nsec ? 32'h0 : m_sctrl;
      10'd9: return nsec ? 32'h0 : (sstat_i & 32'hFFFF);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a, input bit nsec);
    case (a[11:2])
      10'd0: return "R2";
      10'd1: return "R3";
      10'd2: return "R4";
      10'd4, 10'd5, 10'd6, 10'd7: return "R6";
      10'd8, 10'd9: return nsec ? "R7" : "R2/R3 secure";
      default: return "R8";
    endcase
  endfunction

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d,
                           input logic [3:0] s, input bit nsec);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d; pstrb = s;
    pprot = {1'b0, nsec, 1'b0};
    @(negedge pclk);
    penable = 1;
    #2;
    chk("R9 pready", {63'h0, pready}, 64'h1);
    chk("R9 pslverr", {63'h0, pslverr}, 64'h0);
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
    model_write(a, d, s, nsec);
  endtask

  task automatic apb_read(input logic [11:0] a, input bit nsec, output logic [31:0] d);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 0; paddr = a; pprot = {1'b0, nsec, 1'b0};
    @(negedge pclk);
    penable = 1;
    #2;
    d = prdata;
    chk("R9 pready", {63'h0, pready}, 64'h1);
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  task automatic check_outputs(input string req);
    chk({req, " ctrl_o"},  {32'h0, ctrl_o},  {32'h0, m_ctrl});
    chk({req, " cmd_o"},   {32'h0, cmd_o},   {32'h0, m_cmd});
    chk({req, " base_o"},  base_o,           {m_bhi, m_blo});
    chk({req, " sctrl_o"}, {32'h0, sctrl_o}, {32'h0, m_sctrl});
  endtask

  task automatic read_all();
    logic [31:0] r;
    for (int off = 0; off < 16; off++) begin
      for (int n = 0; n < 2; n++) begin
        apb_read(12'(off * 4), n[0], r);
        chk(tag_of(12'(off * 4), n[0]), {32'h0, r}, {32'h0, model_read(12'(off * 4), n[0])});
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge pclk);
    presetn = 1;
    // R1: reset state
    check_outputs("R1");
    apb_read(12'h000, 1'b0, r); chk("R1 CTRL read", {32'h0, r}, 64'h0);
    apb_read(12'h010, 1'b0, r); chk("R1 BASE lo read", {32'h0, r}, 64'h0);
    apb_read(12'h020, 1'b0, r); chk("R1 SCTRL read", {32'h0, r}, 64'h0);

    // Sweep: every offset, both security states, varied strobes and data
    for (int rnd = 0; rnd < 4; rnd++) begin
      logic [3:0] s;
      logic [31:0] p;
      s = (rnd == 0) ? 4'hF : (rnd == 1) ? 4'h5 : (rnd == 2) ? 4'hA : 4'hF;
      p = 32'hA5C3_5A3C ^ (32'h1357_9BDF * (rnd + 1));
      stat_i  = 32'hDEAD_BE00 + rnd;
      cnt_i   = {32'h0123_4567 + rnd, 32'h89AB_CDEF - rnd};
      sstat_i = 32'hCAFE_F00D ^ rnd;
      for (int off = 0; off < 16; off++) begin
        for (int n = 0; n < 2; n++) begin
          apb_write(12'(off * 4), p ^ (32'h0101_0101 * off) ^ (n ? 32'hFFFF_FFFF : 32'h0), s, n[0]);
        end
      end
      check_outputs("R5 sweep");
      read_all();
    end

    // R3: write to RO word leaves read value as the status input
    stat_i = 32'h0000_0042;
    apb_write(12'h004, 32'hFFFF_FFFF, 4'hF, 1'b0);
    apb_read(12'h004, 1'b0, r); chk("R3 RO after write", {32'h0, r}, 64'h42);

    // R4: CMD write reaches cmd_o masked, reads zero
    apb_write(12'h008, 32'hFFFF_F123, 4'hF, 1'b0);
    chk("R4 cmd_o", {32'h0, cmd_o}, 64'h123);
    apb_read(12'h008, 1'b0, r); chk("R4 CMD read", {32'h0, r}, 64'h0);

    // R5: single-byte strobe on CTRL
    apb_write(12'h000, 32'h0000_0000, 4'hF, 1'b0);
    apb_write(12'h000, 32'hFFFF_FFFF, 4'b0010, 1'b0);
    chk("R5 byte1 only", {32'h0, ctrl_o}, 64'h0000_FF00);

    // R6: halves independent
    apb_write(12'h010, 32'h0, 4'hF, 1'b0);
    apb_write(12'h014, 32'h0000_BEEF, 4'hF, 1'b0);
    apb_write(12'h010, 32'hFFFF_FFFF, 4'hF, 1'b0);
    chk("R6 base halves", base_o, 64'h0000_BEEF_FFFF_FFC0);

    // R7: secure write then non-secure attempt
    apb_write(12'h020, 32'h0000_005A, 4'hF, 1'b0);
    apb_write(12'h020, 32'h0000_00FF, 4'hF, 1'b1);
    chk("R7 sctrl_o kept", {32'h0, sctrl_o}, 64'h5A);
    apb_read(12'h020, 1'b1, r); chk("R7 ns read", {32'h0, r}, 64'h0);
    apb_read(12'h020, 1'b0, r); chk("R7 s read", {32'h0, r}, 64'h5A);

    // R8: write to a deliberately empty offset changes nothing
    apb_write(12'h02C, 32'hFFFF_FFFF, 4'hF, 1'b0);
    check_outputs("R8 empty offset");
    apb_read(12'h02C, 1'b0, r); chk("R8 empty read", {32'h0, r}, 64'h0);

    // R10: setup phase with no access phase
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 1; paddr = 12'h000; pwdata = 32'h0000_1234; pstrb = 4'hF;
    pprot = 3'b000;
    @(negedge pclk);
    psel = 0; pwrite = 0;
    @(negedge pclk);
    chk("R10 setup only", {32'h0, ctrl_o}, {32'h0, m_ctrl});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule